// File: doc/BRIEF.md
# Carry-Propagate Final Adder

This block adds two W-bit vectors and returns their sum modulo 2^W. There is no carry input and no carry output. It is the last stage after a carry-save reduction tree has cut many operands down to two. The block is purely combinational, so the sum is valid in the same cycle as its operands.

A parameter picks how the carries are built:

- **Ripple:** a linear carry chain.
- **Prefix:** a Kogge-Stone parallel-prefix network.
- **Automatic:** the prefix network is used only when the operands are wide and also arrive late. Arrival is given as the number of compressor levels in front of the adder. In every other case the ripple chain is used.

Both structures start from per-bit generate (`a AND b`) and propagate (`a XOR b`) terms. The prefix network leaves out the group-propagate terms at its last level, because nothing reads them. The carry out of the most significant bit is never built.

Top module: `cpa_final_adder`

## Requirements
- R1: For every operand pair, `sum_o` equals `(op_a + op_b) mod 2^WIDTH`, whichever structure is selected.
- R2: The carry into bit 0 is zero. Two zero operands give a zero sum, and `sum_o[0]` always equals `op_a[0] XOR op_b[0]`.
- R3: A carry out of the top bit is discarded. The all-ones value plus one gives zero.
- R4: With WIDTH = 1, the output is `op_a XOR op_b` in both structures.
- R5: The ripple structure matches R1 for every one of the 65,536 operand pairs at WIDTH = 8.
- R6: The prefix structure matches R1 at widths that are not powers of two: exhaustively in the low byte, and at WIDTH 2, 5 and 13.
- R7: In automatic mode, the prefix network is used only when WIDTH ≥ 16 and the input depth ≥ 5; otherwise the ripple chain is used. At the threshold corners (16/5, 16/4, 15/9) the output still satisfies R1.
- R8: Carries that run the full width are correct. Alternating-bit operands that complement each other sum to all ones, and all-ones plus all-ones gives all ones except bit 0.
- R9: The output settles within the cycle in which the operands change, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| sum_o | output | WIDTH | `(op_a + op_b) mod 2^WIDTH` |

## Verification
The block holds no state. A wrong carry term therefore shows up at `sum_o` in the same cycle as the operands that exercise it.

A fault in one prefix level only shows when its span is exercised. Typical cases are a wrong offset `i-s` or a pruned propagate that is in fact needed. Such faults corrupt only the sums whose carry must cross that span. For this reason, long carry patterns (all ones, alternating bits, plus one) and exhaustive low-byte sweeps are used to hit every span.

A wrong automatic choice cannot be seen at the ports. Each of the two outcomes is therefore checked for correctness at the threshold corners.

// File: rtl/cpa_pkg.sv
// Shared definitions for the carry-propagate final adder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cpa_pkg;

    // Carry structure selection.
    typedef enum logic [1:0] {
        ARCH_RIPPLE = 2'd0,
        ARCH_PREFIX = 2'd1,
        ARCH_AUTO   = 2'd2
    } arch_e;

    // Default automatic-mode thresholds (width, arrival depth).
    localparam int DEF_WIDE_MIN = 16;
    localparam int DEF_DEEP_MIN = 5;

    // Decide at elaboration whether the prefix network is built.
    function automatic bit pick_prefix(arch_e arch, int width, int depth,
                                       int wide_min, int deep_min);
        case (arch)
            ARCH_RIPPLE: return 1'b0;
            ARCH_PREFIX: return 1'b1;
            default:     return (width >= wide_min) && (depth >= deep_min);
        endcase
    endfunction

endpackage

// File: rtl/cpa_pg.sv
// Per-bit generate/propagate terms.
// Propagate is produced for all WIDTH bits (the sum needs it).
// Generate is produced only for bits 0..WIDTH-2, since the top bit's
// carry out is dropped. Assumes WIDTH >= 2.
module cpa_pg #(
    parameter int WIDTH = 8,
    localparam int GW   = WIDTH - 1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] p,
    output logic [GW-1:0]    g
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_prop
        // Bit propagate: carry passes through when exactly one input is set.
        assign p[i] = a[i] ^ b[i];
    end

    for (genvar i = 0; i < GW; i++) begin : g_gen
        // Bit generate: carry created when both inputs are set.
        assign g[i] = a[i] & b[i];
    end

endmodule

// File: rtl/cpa_ripple.sv
// Linear carry chain over N bit positions.
// c[i] is the carry out of bit i, i.e. the carry into bit i+1.
// The carry into bit 0 is zero, so c[0] = g[0] and p[0] is not needed.
// Assumes N >= 2.
module cpa_ripple #(
    parameter int N = 7
) (
    input  logic [N-1:0] g,
    input  logic [N-1:1] p,
    output logic [N-1:0] c
);

    // Bit 0: no carry-in, so only its own generate.
    assign c[0] = g[0];

    for (genvar i = 1; i < N; i++) begin : g_chain
        // Carry out of bit i from its own terms and the carry below.
        assign c[i] = g[i] | (p[i] & c[i-1]);
    end

endmodule

// File: rtl/cpa_prefix.sv
// Kogge-Stone parallel-prefix carry network over N bit positions.
// The network has ceil(log2 N) levels. Level k combines each bit with
// the bit 2^(k-1) positions below it; bits under that span pass through
// unchanged. Group propagate is not formed at the final level, because
// no later level reads it.
// Output c[i] is the group generate of bits i..0, i.e. the carry out
// of bit i with zero carry-in. Assumes N >= 2.
module cpa_prefix #(
    parameter int N = 7,
    localparam int LVL = $clog2(N)
) (
    input  logic [N-1:0] g,
    input  logic [N-1:0] p,
    output logic [N-1:0] c
);

    // Build all prefix levels and return the final group generates.
    function automatic logic [N-1:0] scan(input logic [N-1:0] gi,
                                          input logic [N-1:0] pi);
        logic [N-1:0] gc, pc, gn, pn;
        gc = gi;
        pc = pi;
        for (int k = 1; k <= LVL; k++) begin
            int s;
            s  = 1 << (k - 1);
            gn = gc;
            pn = pc;
            for (int i = s; i < N; i++) begin
                gn[i] = gc[i] | (pc[i] & gc[i-s]);
                if (k < LVL) begin
                    pn[i] = pc[i] & pc[i-s];
                end
            end
            gc = gn;
            pc = pn;
        end
        return gc;
    endfunction

    // Evaluate the prefix network.
    always_comb begin
        c = scan(g, p);
    end

endmodule

// File: rtl/cpa_final_adder.sv
// Two-operand final adder: sum_o = (op_a + op_b) mod 2^WIDTH.
// Combinational, with no carry-in and no carry-out.
// ARCH picks a ripple chain, a Kogge-Stone prefix network, or an
// automatic choice. In automatic mode the prefix network is used when
// WIDTH >= WIDE_MIN and IN_DEPTH >= DEEP_MIN.
// IN_DEPTH is the number of compressor levels in front of this adder.
// Assumes WIDTH >= 1.
module cpa_final_adder
    import cpa_pkg::*;
#(
    parameter int    WIDTH    = 32,
    parameter arch_e ARCH     = ARCH_AUTO,
    parameter int    IN_DEPTH = 6,
    parameter int    WIDE_MIN = DEF_WIDE_MIN,
    parameter int    DEEP_MIN = DEF_DEEP_MIN
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum_o
);

    localparam bit USE_PREFIX = pick_prefix(ARCH, WIDTH, IN_DEPTH, WIDE_MIN, DEEP_MIN);
    localparam int NC         = (WIDTH > 1) ? WIDTH - 1 : 1;

    if (WIDTH < 1) begin : g_bad
        $error("cpa_final_adder: WIDTH must be at least 1");
    end else if (WIDTH == 1) begin : g_one
        // Single bit: the sum is the XOR; the carry is dropped.
        assign sum_o = op_a ^ op_b;
    end else begin : g_multi
        logic [WIDTH-1:0] p;
        logic [NC-1:0]    g;
        logic [NC-1:0]    c;

        cpa_pg #(.WIDTH(WIDTH)) u_pg (
            .a (op_a),
            .b (op_b),
            .p (p),
            .g (g)
        );

        if (NC == 1) begin : g_two
            // Two bits: the only carry needed is the generate of bit 0.
            assign c = g;
        end else if (USE_PREFIX) begin : g_pfx
            cpa_prefix #(.N(NC)) u_pfx (
                .g (g),
                .p (p[NC-1:0]),
                .c (c)
            );
        end else begin : g_rpl
            cpa_ripple #(.N(NC)) u_rpl (
                .g (g),
                .p (p[NC-1:1]),
                .c (c)
            );
        end

        // Sum layer: bit 0 is its own propagate; bit i XORs in carry i-1.
        assign sum_o = p ^ {c, 1'b0};
    end

endmodule

// File: rtl/cpa_final_adder_chk.sv
// Port-level checker for cpa_final_adder.
// The block has no clock, so these are immediate checks evaluated
// whenever the operands or the sum change.
module cpa_final_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] sum_o
);

    localparam logic [WIDTH-1:0] ONES = '1;

    // Check the sum against port-level identities.
    always_comb begin
        // R1
        mod_sum_chk: assert (sum_o == WIDTH'(op_a + op_b))
            else $error("sum mismatch");
        // R2
        lsb_no_cin_chk: assert (sum_o[0] == (op_a[0] ^ op_b[0]))
            else $error("bit 0 sees a carry-in");
        // R3
        wrap_chk: assert (!((op_a == ONES) && (op_b == WIDTH'(1))) || (sum_o == '0))
            else $error("top carry not discarded");
        // R8
        no_carry_chk: assert (!((op_a & op_b) == '0) || (sum_o == (op_a | op_b)))
            else $error("spurious carry");
    end

endmodule

bind cpa_final_adder cpa_final_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a  (op_a),
    .op_b  (op_b),
    .sum_o (sum_o)
);

// File: tb/test_cpa_final_adder.sv
// Self-checking bench. Every configuration is driven from one pair of
// 64-bit vectors. Each output is compared with a behavioural sum half a
// cycle after the drive.
module test_cpa_final_adder;
    import cpa_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] va = '0;
    logic [63:0] vb = '0;
    int          nrun = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    logic [0:0]  s1p, s1r;
    logic [1:0]  s2p;
    logic [4:0]  s5p;
    logic [7:0]  s8r, s8p;
    logic [12:0] s13p;
    logic [14:0] s15a;
    logic [15:0] s16a5, s16a4;
    logic [31:0] s32;
    logic [63:0] s64p;

    cpa_final_adder #(.WIDTH(32)) i_cpa_final_adder (.op_a(va[31:0]), .op_b(vb[31:0]), .sum_o(s32));
    cpa_final_adder #(.WIDTH(1),  .ARCH(ARCH_PREFIX)) i_w1p  (.op_a(va[0:0]),  .op_b(vb[0:0]),  .sum_o(s1p));
    cpa_final_adder #(.WIDTH(1),  .ARCH(ARCH_RIPPLE)) i_w1r  (.op_a(va[0:0]),  .op_b(vb[0:0]),  .sum_o(s1r));
    cpa_final_adder #(.WIDTH(2),  .ARCH(ARCH_PREFIX)) i_w2p  (.op_a(va[1:0]),  .op_b(vb[1:0]),  .sum_o(s2p));
    cpa_final_adder #(.WIDTH(5),  .ARCH(ARCH_PREFIX)) i_w5p  (.op_a(va[4:0]),  .op_b(vb[4:0]),  .sum_o(s5p));
    cpa_final_adder #(.WIDTH(8),  .ARCH(ARCH_RIPPLE)) i_w8r  (.op_a(va[7:0]),  .op_b(vb[7:0]),  .sum_o(s8r));
    cpa_final_adder #(.WIDTH(8),  .ARCH(ARCH_PREFIX)) i_w8p  (.op_a(va[7:0]),  .op_b(vb[7:0]),  .sum_o(s8p));
    cpa_final_adder #(.WIDTH(13), .ARCH(ARCH_PREFIX)) i_w13p (.op_a(va[12:0]), .op_b(vb[12:0]), .sum_o(s13p));
    cpa_final_adder #(.WIDTH(15), .IN_DEPTH(9)) i_w15a  (.op_a(va[14:0]), .op_b(vb[14:0]), .sum_o(s15a));
    cpa_final_adder #(.WIDTH(16), .IN_DEPTH(5)) i_w16a5 (.op_a(va[15:0]), .op_b(vb[15:0]), .sum_o(s16a5));
    cpa_final_adder #(.WIDTH(16), .IN_DEPTH(4)) i_w16a4 (.op_a(va[15:0]), .op_b(vb[15:0]), .sum_o(s16a4));
    cpa_final_adder #(.WIDTH(64), .ARCH(ARCH_PREFIX)) i_w64p (.op_a(va), .op_b(vb), .sum_o(s64p));

    function automatic logic [63:0] msk(int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    // Compare one output with its expected value.
    task automatic cmp(string req, int w, logic [63:0] got, logic [63:0] exp);
        nrun++;
        if ((got & msk(w)) !== (exp & msk(w))) begin
            nfail++;
            $display("FAIL %s W=%0d a=%h b=%h actual=%h expected=%h",
                     req, w, va & msk(w), vb & msk(w), got & msk(w), exp & msk(w));
        end
    endtask

    // Compare one output with the behavioural modular sum.
    task automatic chk(string req, int w, logic [63:0] got);
        cmp(req, w, got, (va & msk(w)) + (vb & msk(w)));
    endtask

    // Drive operands on a rising edge; return on the following falling edge.
    task automatic drive(logic [63:0] a, logic [63:0] b);
        @(posedge clk);
        va = a;
        vb = b;
        @(negedge clk);
    endtask

    // Reference comparison of every configuration.
    task automatic check_all();
        chk("R4", 1, 64'(s1p));
        chk("R4", 1, 64'(s1r));
        chk("R6", 2, 64'(s2p));
        chk("R6", 5, 64'(s5p));
        chk("R5", 8, 64'(s8r));
        chk("R1", 8, 64'(s8p));
        chk("R6", 13, 64'(s13p));
        chk("R7", 15, 64'(s15a));
        chk("R7", 16, 64'(s16a5));
        chk("R7", 16, 64'(s16a4));
        chk("R1", 32, 64'(s32));
        chk("R1", 64, s64p);
    endtask

    // Main stimulus.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R2: zero operands give zero; no carry into bit 0.
        drive('0, '0);
        cmp("R2", 32, 64'(s32), '0);
        cmp("R2", 64, s64p, '0);
        drive(64'h1, 64'h0);
        cmp("R2", 64, 64'(s64p[0]), 64'h1);
        check_all();

        // R3: all ones plus one wraps to zero.
        drive('1, 64'h1);
        cmp("R3", 32, 64'(s32), '0);
        cmp("R3", 64, s64p, '0);
        cmp("R3", 16, 64'(s16a4), '0);
        check_all();

        // R8: long carry patterns.
        drive(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA);
        cmp("R8", 64, s64p, '1);
        cmp("R8", 13, 64'(s13p), 64'h1FFF);
        check_all();
        drive('1, '1);
        cmp("R8", 64, s64p, 64'hFFFF_FFFF_FFFF_FFFE);
        cmp("R8", 32, 64'(s32), 64'hFFFF_FFFE);
        check_all();
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA);
        check_all();

        // R9: sampled half a cycle after the drive, with no register delay.
        drive(64'h0000_0000_7FFF_FFFF, 64'h1);
        cmp("R9", 32, 64'(s32), 64'h8000_0000);

        // R5 and R6: exhaustive low byte; upper bits random.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [63:0] ra, rb;
                ra = {$urandom(), $urandom()};
                rb = {$urandom(), $urandom()};
                ra[7:0] = x[7:0];
                rb[7:0] = y[7:0];
                drive(ra, rb);
                check_all();
            end
        end

        // R1 and R7: random operands, mixed with edge patterns.
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            case (n % 5)
                1: ra = '1;
                2: rb = ~ra;
                3: begin ra = 64'h5555_5555_5555_5555; rb = ~ra + 64'(n % 3); end
                default: ;
            endcase
            drive(ra, rb);
            check_all();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

endmodule